// File: doc/BRIEF.md
# Line-Half-Cycle Gated Dual PWM

This block drives the two gate signals of a bridgeless two-switch power converter. A free-running counter produces a switching carrier. Comparing that carrier with a programmable duty value gives a single pulse-width-modulated level. A slow square wave at line frequency, built inside the block, marks which half of the supply cycle is active. The pulse train goes to the first gate while that wave is in its positive half and to the second gate while it is in its negative half. Only one switch is ever pulsed, and the idle one is held low.

A new duty value is taken only at the end of a carrier period. The half-cycle flag also changes only at that boundary. As a result, every pulse is either whole or absent: none is truncated by a duty update or by the handover between gates. The carrier length and the number of carrier periods per half line cycle are parameters. The defaults give a 20 kHz carrier and a 50 Hz line wave from a 100 MHz clock.

Top module: `line_gated_dual_pwm`

## Requirements
- R1: The carrier repeats every CARRIER_CLKS clocks. Its count runs from 0 to CARRIER_CLKS-1 and then returns to 0.
- R2: While `half_pos` is 1, `gate_a` is high exactly while the carrier count is below the latched duty value, and `gate_b` is low.
- R3: While `half_pos` is 0, `gate_b` is high exactly while the carrier count is below the latched duty value, and `gate_a` is low.
- R4: `half_pos` is 1 for the positive half and 0 for the negative half. It inverts after every HALF_CARRIERS carrier periods, and only at the clock where the carrier returns to 0.
- R5: A latched duty value of 0 keeps both gates low for the whole period.
- R6: A latched duty value at or above CARRIER_CLKS holds the active half's gate high for the whole period, while the other gate stays low.
- R7: While `enable` is 0 both gates are low. The carrier and the half-cycle timing keep running unchanged.
- R8: While `rst` is 1 both gates are low. A synchronous reset restarts the carrier at count 0, the half-period count at 0 and `half_pos` at 1.
- R9: `duty_cmp` is captured only on the clock edge where the carrier wraps. A change at any other time has no effect on the gates until the next period begins.
- R10: `gate_a` and `gate_b` are never high together.
- R11: Until the first carrier wrap after reset, the latched duty value is CARRIER_CLKS/2, which gives 50 percent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Gate output enable, active high |
| duty_cmp | input | DUTY_W | Requested duty compare value, in clocks of high time per period |
| gate_a | output | 1 | Gate drive of the switch used in the positive half |
| gate_b | output | 1 | Gate drive of the switch used in the negative half |
| half_pos | output | 1 | Half-cycle flag, 1 for positive half, 0 for negative half |

## Verification
The hardest case to reach from the ports is a half-cycle handover that lands on the same wrap as a duty update, with a reset arriving partway through a half. With default parameters these events are a million clocks apart. The bench therefore shrinks the carrier to 20 clocks and the half period to three carriers. It then changes the duty value at random moments, including right at wraps, and inserts resets at random points. The handover, duty capture and reset restart then occur hundreds of times and in many combinations.

// File: rtl/hcpwm_pkg.sv
package hcpwm_pkg;

  // Line half-cycle phase; the encoding matches the half_pos output.
  typedef enum logic {
    PHASE_NEG = 1'b0,
    PHASE_POS = 1'b1
  } phase_e;

  // Pulse is active while the carrier position is below the duty value.
  function automatic logic pwm_on(input int unsigned pos, input int unsigned duty);
    return pos < duty;
  endfunction

  // True on the final count of a period of the given length.
  function automatic logic at_last(input int unsigned pos, input int unsigned period);
    return pos == period - 1;
  endfunction

  // Duty loaded by reset: half of the carrier period.
  function automatic int unsigned default_duty(input int unsigned period);
    return period / 2;
  endfunction

  // Width needed to count 0..n-1, never below one bit.
  function automatic int unsigned count_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/hcpwm_carrier.sv
module hcpwm_carrier
  import hcpwm_pkg::*;
#(
  parameter int unsigned CARRIER_CLKS = 5000,
  parameter int unsigned CW           = count_width(CARRIER_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  localparam logic [CW-1:0] LAST = CW'(CARRIER_CLKS - 1);

  assign wrap = at_last(32'(cnt), CARRIER_CLKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R1: the last count is always followed by count zero
  assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |=> (cnt == '0));

  // R1: away from the last count the carrier advances by one
  assert_step_by_one_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt != LAST) |=> (cnt == $past(cnt) + CW'(1)));

  // R1: the count never leaves its range
  assert_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/hcpwm_duty_latch.sv
module hcpwm_duty_latch
  import hcpwm_pkg::*;
#(
  parameter int unsigned CARRIER_CLKS = 5000,
  parameter int unsigned DUTY_W       = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] duty_in,
  output logic [DUTY_W-1:0] duty_q
);

  localparam logic [DUTY_W-1:0] RESET_DUTY = DUTY_W'(default_duty(CARRIER_CLKS));

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= RESET_DUTY;
    end else if (wrap) begin
      duty_q <= duty_in;
    end
  end

  // R9: between wraps the latched duty cannot move
  assert_duty_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(duty_q));

  // R9: at a wrap the requested value is the one taken
  assert_duty_take_R9: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (duty_q == $past(duty_in)));

endmodule

// File: rtl/hcpwm_line_phase.sv
module hcpwm_line_phase
  import hcpwm_pkg::*;
#(
  parameter int unsigned HALF_CARRIERS = 200
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   wrap,
  output phase_e phase,
  output logic   flip
);

  localparam int unsigned HW = count_width(HALF_CARRIERS);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CARRIERS - 1);

  logic [HW-1:0] half_cnt;

  assign flip = wrap && at_last(32'(half_cnt), HALF_CARRIERS);

  always_ff @(posedge clk) begin
    if (rst) begin
      half_cnt <= '0;
      phase    <= PHASE_POS;
    end else if (wrap) begin
      if (flip) begin
        half_cnt <= '0;
        phase    <= (phase == PHASE_POS) ? PHASE_NEG : PHASE_POS;
      end else begin
        half_cnt <= half_cnt + HW'(1);
      end
    end
  end

  // R4: the phase changes only on a flip event
  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !flip |=> $stable(phase));

  // R4: every flip event inverts the phase
  assert_phase_invert_R4: assert property (@(posedge clk) disable iff (rst)
    flip |=> (phase != $past(phase)));

  // R4: the half-period count stays in range
  assert_half_range_R4: assert property (@(posedge clk) disable iff (rst)
    half_cnt <= HALF_LAST);

endmodule

// File: rtl/hcpwm_gate_steer.sv
module hcpwm_gate_steer
  import hcpwm_pkg::*;
#(
  parameter int unsigned CW     = 13,
  parameter int unsigned DUTY_W = 13
) (
  input  logic              rst,
  input  logic              enable,
  input  logic [CW-1:0]     cnt,
  input  logic [DUTY_W-1:0] duty_q,
  input  phase_e            phase,
  output logic [1:0]        gate
);

  logic pwm;

  assign pwm = pwm_on(32'(cnt), 32'(duty_q));

  // Channel 0 serves the positive half, channel 1 the negative half.
  for (genvar k = 0; k < 2; k++) begin : g_chan
    localparam phase_e OWNER = (k == 0) ? PHASE_POS : PHASE_NEG;
    assign gate[k] = !rst && enable && (phase == OWNER) && pwm;
  end

endmodule

// File: rtl/line_gated_dual_pwm.sv
module line_gated_dual_pwm
  import hcpwm_pkg::*;
#(
  parameter int unsigned CARRIER_CLKS  = 5000,
  parameter int unsigned HALF_CARRIERS = 200,
  parameter int unsigned DUTY_W        = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DUTY_W-1:0] duty_cmp,
  output logic              gate_a,
  output logic              gate_b,
  output logic              half_pos
);

  localparam int unsigned CW = count_width(CARRIER_CLKS);

  // Named internal events used by the assertions below
  logic [CW-1:0]     carrier_cnt;
  logic              carrier_wrap;
  logic [DUTY_W-1:0] duty_q;
  phase_e            phase;
  logic              phase_flip;
  logic [1:0]        gate;

  hcpwm_carrier #(
    .CARRIER_CLKS (CARRIER_CLKS),
    .CW           (CW)
  ) u_carrier (
    .clk  (clk),
    .rst  (rst),
    .cnt  (carrier_cnt),
    .wrap (carrier_wrap)
  );

  hcpwm_duty_latch #(
    .CARRIER_CLKS (CARRIER_CLKS),
    .DUTY_W       (DUTY_W)
  ) u_duty (
    .clk     (clk),
    .rst     (rst),
    .wrap    (carrier_wrap),
    .duty_in (duty_cmp),
    .duty_q  (duty_q)
  );

  hcpwm_line_phase #(
    .HALF_CARRIERS (HALF_CARRIERS)
  ) u_phase (
    .clk   (clk),
    .rst   (rst),
    .wrap  (carrier_wrap),
    .phase (phase),
    .flip  (phase_flip)
  );

  hcpwm_gate_steer #(
    .CW     (CW),
    .DUTY_W (DUTY_W)
  ) u_steer (
    .rst    (rst),
    .enable (enable),
    .cnt    (carrier_cnt),
    .duty_q (duty_q),
    .phase  (phase),
    .gate   (gate)
  );

  assign gate_a   = gate[0];
  assign gate_b   = gate[1];
  assign half_pos = (phase == PHASE_POS);

  // R10: the two switches are never driven together
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(gate_a && gate_b));

  // R4: a half-cycle handover happens only at a carrier wrap
  assert_flip_at_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    phase_flip |-> carrier_wrap);

  // R5: a zero duty gives no pulse on either gate
  assert_zero_duty_R5: assert property (@(posedge clk) disable iff (rst)
    (duty_q == '0) |-> (!gate_a && !gate_b));

  // R2: the first gate pulses only in the positive half
  assert_a_in_pos_R2: assert property (@(posedge clk) disable iff (rst)
    gate_a |-> half_pos);

  // R3: the second gate pulses only in the negative half
  assert_b_in_neg_R3: assert property (@(posedge clk) disable iff (rst)
    gate_b |-> !half_pos);

  // R7: no pulse while the outputs are disabled
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (!gate_a && !gate_b));

  // R8: reset holds both gates low
  always_comb begin
    if (rst) begin
      assert_reset_quiet_R8: assert (!gate_a && !gate_b);
    end
  end

endmodule

// File: tb/line_gated_dual_pwm_tb_top.sv
module line_gated_dual_pwm_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned P          = 20;   // carrier clocks
  localparam int unsigned H          = 3;    // carriers per half cycle
  localparam int unsigned DW         = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b1;
  logic [DW-1:0] duty_cmp = '0;
  logic          gate_a;
  logic          gate_b;
  logic          half_pos;

  int errors = 0;
  int checks = 0;
  int cycle  = 0;

  line_gated_dual_pwm #(
    .CARRIER_CLKS  (P),
    .HALF_CARRIERS (H),
    .DUTY_W        (DW)
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .duty_cmp (duty_cmp),
    .gate_a   (gate_a),
    .gate_b   (gate_b),
    .half_pos (half_pos)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Reference state built from the requirements
  int unsigned r_cnt;
  int unsigned r_duty;
  int unsigned r_hc;
  logic        r_half;
  logic        r_fresh;

  function automatic logic exp_pulse(input int unsigned pos, input int unsigned duty);
    return duty > pos;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b cycle=%0d", req, act, exp, cycle);
    end
  endtask

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (rst) begin
      r_cnt   = 0;
      r_duty  = P / 2;
      r_hc    = 0;
      r_half  = 1'b1;
      r_fresh = 1'b1;
    end else if (r_cnt == P - 1) begin
      r_cnt   = 0;
      r_duty  = int'(duty_cmp);
      r_fresh = 1'b0;
      if (r_hc == H - 1) begin
        r_hc   = 0;
        r_half = !r_half;
      end else begin
        r_hc++;
      end
    end else begin
      r_cnt++;
    end
  end

  // Per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    logic p;
    logic [1:0] exp;
    string tag;
    if (rst) begin
      check("R8", {gate_a, gate_b}, 2'b00);
    end else if (r_duty !== 'x && r_cnt !== 'x) begin
      p   = enable && exp_pulse(r_cnt, r_duty);
      exp = {p && r_half, p && !r_half};
      if (!enable)                    tag = "R7";
      else if (r_duty == 0)           tag = "R5";
      else if (r_duty >= P)           tag = "R6";
      else if (r_fresh)               tag = "R11";
      else if (int'(duty_cmp) != r_duty) tag = "R9";
      else if (r_half)                tag = "R2";
      else                            tag = "R3";
      check(tag, {gate_a, gate_b}, exp);
      check("R10", {1'b0, gate_a && gate_b}, 2'b00);
      check("R4", {1'b0, half_pos}, {1'b0, r_half});
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // R1: distance between successive pulse starts equals the carrier period
  task automatic measure_period();
    int t0;
    int t1;
    logic prev;
    logic cur;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      cur = gate_a | gate_b;
      if (!prev && cur) break;
      prev = cur;
    end
    t0 = cycle;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      cur = gate_a | gate_b;
      if (!prev && cur) break;
      prev = cur;
    end
    t1 = cycle;
    check("R1", 2'(t1 - t0 == int'(P)), 2'b01);
  endtask

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd7321);
    // Reset with a pending request different from the default duty (R11, R8)
    rst = 1'b1;
    enable = 1'b1;
    duty_cmp = DW'(7);
    step(4);
    rst = 1'b0;
    step(3 * P);
    // R1 with a fixed mid duty
    duty_cmp = DW'(5);
    step(P);
    measure_period();
    step(1);
    measure_period();
    // R5 zero duty across a handover
    duty_cmp = '0;
    step(3 * H * P);
    // R6 full on, exactly the period and the largest code
    duty_cmp = DW'(P);
    step(2 * H * P);
    duty_cmp = '1;
    step(2 * H * P);
    // R7 disabled while the timing continues
    duty_cmp = DW'(9);
    enable = 1'b0;
    step(2 * H * P + 7);
    enable = 1'b1;
    step(2 * H * P);
    // R9 mid-period changes
    for (int i = 0; i < 20; i++) begin
      duty_cmp = DW'($urandom % (P + 4));
      step(3 + ($urandom % 5));
    end
    // R8 reset in the middle of a negative half
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(2 * H * P);
    // Constrained random mix
    for (int i = 0; i < 300; i++) begin
      int unsigned pick;
      pick = $urandom % 8;
      case (pick)
        0:       duty_cmp = '0;
        1:       duty_cmp = DW'(P + ($urandom % 4));
        2:       duty_cmp = DW'(P - 1);
        3:       duty_cmp = DW'(1);
        default: duty_cmp = DW'($urandom % P);
      endcase
      enable = ($urandom % 8) != 0;
      if (($urandom % 40) == 0) begin
        rst = 1'b1;
        step(1 + ($urandom % 3));
        rst = 1'b0;
      end
      step(1 + ($urandom % (2 * P)));
    end
    step(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule